// File: doc/BRIEF.md
# Cascadable Prescaled Timer Bank

A bank of four 16-bit up-counters sits behind a small 16-bit register bus. Each timer holds a reload value and a control word. A timer advances on ticks of its own clock divider, or, in cascade mode, once for each overflow of the timer directly below it. When a timer passes 0xFFFF it takes the reload value again, keeps counting, and can raise an interrupt request.

Software programs a timer by writing its reload value and then a control word with the run bit set. It reads the live count at the same address as the reload value. Chained timers give counts longer than 16 bits without extra hardware. Interrupt arbitration and any DMA triggering are handled outside this block.

Top module: `timer_bank`

## Requirements
- R1: After reset every counter, reload value and control word is zero, and `irq_o` is low.
- R2: Word address 2n writes the reload value of timer n and reads its live count. Word address 2n+1 writes and reads its control word. Only control bits [7] run, [6] interrupt enable, [2] cascade and [1:0] divider select are kept, so writing 0xFFFF reads back as 0x00C7.
- R3: Divider select 0, 1, 2 and 3 makes a running timer advance every 1, 64, 256 or 1024 clocks. The first advance comes exactly that many clocks after the write that set the run bit.
- R4: A control write that sets the run bit on a stopped timer loads the counter from the reload value and restarts its divider. The same write on a timer that is already running does not reload the counter.
- R5: A timer that advances from 0xFFFF loads the reload value and continues. The overflow period is therefore (0x10000 − reload) × divide ratio clocks.
- R6: Writing the reload value leaves a running counter unchanged. The new value takes effect at the next overflow or the next start.
- R7: Clearing the run bit freezes the counter at the value it has reached.
- R8: `irq_o[n]` is high for the single clock cycle after each overflow of timer n, and only when its interrupt enable bit is set.
- R9: Timer n>0 in cascade mode ignores its divider and advances once per overflow of timer n−1, in the same cycle as that overflow, so an overflow can ripple up the chain. The top timer drives nothing above it.
- R10: Timer 0 ignores its cascade bit and counts divider ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register at `addr_i` |
| addr_i | input | 3 | Word address: 2n is reload/count, 2n+1 is control |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 4 | One-cycle overflow interrupt pulse per timer |

## Verification
The bench samples the count exactly one edge before and one edge after each divider boundary. A divider that is not cleared at start, or that is off by one, therefore shows up as a wrong count. It rewrites the reload value while a timer is running and checks the count at the following overflow. A design that loads the reload value immediately fails there. So does one that keeps the old reload value past the overflow. It also rewrites the run bit on a timer that is already running, which catches a design that reloads the counter on every enable write. Finally, it drives a single overflow up a chain of three cascaded timers and expects one interrupt on the top timer in the next cycle. Cascade that is registered between stages, or that uses the divider, would delay that interrupt or drop it.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int unsigned DIV_W    = 10;  // widest divide ratio is 2**DIV_W
  localparam int unsigned DIV_SH1  = 6;
  localparam int unsigned DIV_SH2  = 8;
  localparam int unsigned RUN_BIT  = 7;
  localparam int unsigned IRQ_BIT  = 6;
  localparam int unsigned CASC_BIT = 2;

  typedef struct packed {
    logic       run;
    logic       irq_en;
    logic       casc;
    logic [1:0] psel;
  } tmr_ctrl_t;

  function automatic tmr_ctrl_t unpack_ctrl(input logic [7:0] w);
    tmr_ctrl_t c;
    c.run    = w[RUN_BIT];
    c.irq_en = w[IRQ_BIT];
    c.casc   = w[CASC_BIT];
    c.psel   = w[1:0];
    return c;
  endfunction

  function automatic logic [7:0] pack_ctrl(input tmr_ctrl_t c);
    return {c.run, c.irq_en, 3'b000, c.casc, c.psel};
  endfunction
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler
  import timer_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (run_i)  div_q <= div_q + 1'b1;
  end

  // tick on the last count of the selected window
  always_comb begin
    unique case (sel_i)
      2'd0:    tick_o = 1'b1;
      2'd1:    tick_o = &div_q[DIV_SH1-1:0];
      2'd2:    tick_o = &div_q[DIV_SH2-1:0];
      default: tick_o = &div_q;
    endcase
  end
endmodule

// File: rtl/timer_unit.sv
module timer_unit
  import timer_bank_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter bit          HAS_LOWER = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_we_i,
  input  logic             ctrl_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             lower_ovf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output tmr_ctrl_t        ctrl_o,
  output logic             ovf_o,
  output logic             irq_o
);
  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, reload_q;
  logic             irq_q, start, pre_tick, step;

  assign ctrl_d = unpack_ctrl(wdata_i[7:0]);
  assign start  = ctrl_we_i && ctrl_d.run && !ctrl_q.run;

  timer_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .run_i  (ctrl_q.run),
    .sel_i  (ctrl_q.psel),
    .tick_o (pre_tick)
  );

  assign step  = (HAS_LOWER && ctrl_q.casc) ? lower_ovf_i : pre_tick;
  assign ovf_o = ctrl_q.run && step && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      cnt_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (ctrl_we_i)   ctrl_q   <= ctrl_d;
      if (reload_we_i) reload_q <= wdata_i;
      if (start)                     cnt_q <= reload_q;
      else if (ctrl_q.run && step)   cnt_q <= (cnt_q == '1) ? reload_q : cnt_q + 1'b1;
      irq_q <= ovf_o && ctrl_q.irq_en;
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter  int unsigned N_TIMERS = 4,
  parameter  int unsigned CNT_W    = 16,
  localparam int unsigned ADDR_W   = $clog2(2 * N_TIMERS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CNT_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]    rdata_o,
  output logic [N_TIMERS-1:0] irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 1;

  logic [N_TIMERS-1:0][CNT_W-1:0] cnt_w, reload_w;
  logic [N_TIMERS-1:0]            run_w, casc_w, irqen_w, ovf_w;
  tmr_ctrl_t                      ctrl_w [N_TIMERS];
  logic [IDX_W-1:0]               sel_idx;

  assign sel_idx = addr_i[ADDR_W-1:1];

  for (genvar t = 0; t < N_TIMERS; t++) begin : g_tmr
    logic lower;
    if (t == 0) begin : g_base
      assign lower = 1'b0;
    end else begin : g_chain
      assign lower = ovf_w[t-1];
    end

    timer_unit #(
      .CNT_W     (CNT_W),
      .HAS_LOWER (t > 0)
    ) u_tmr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .reload_we_i (wr_en_i && (addr_i == ADDR_W'(2 * t))),
      .ctrl_we_i   (wr_en_i && (addr_i == ADDR_W'(2 * t + 1))),
      .wdata_i     (wdata_i),
      .lower_ovf_i (lower),
      .cnt_o       (cnt_w[t]),
      .reload_o    (reload_w[t]),
      .ctrl_o      (ctrl_w[t]),
      .ovf_o       (ovf_w[t]),
      .irq_o       (irq_o[t])
    );

    assign run_w[t]   = ctrl_w[t].run;
    assign casc_w[t]  = ctrl_w[t].casc;
    assign irqen_w[t] = ctrl_w[t].irq_en;
  end

  always_comb begin
    rdata_o = '0;
    for (int t = 0; t < N_TIMERS; t++) begin
      if (sel_idx == IDX_W'(t))
        rdata_o = addr_i[0] ? CNT_W'(pack_ctrl(ctrl_w[t])) : cnt_w[t];
    end
  end
endmodule

// File: rtl/timer_bank_checker.sv
module timer_bank_checker
  import timer_bank_pkg::*;
#(
  parameter  int unsigned N_TIMERS = 4,
  parameter  int unsigned CNT_W    = 16,
  localparam int unsigned ADDR_W   = $clog2(2 * N_TIMERS)
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           wr_en_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [CNT_W-1:0]               wdata_i,
  input logic [N_TIMERS-1:0]            irq_o,
  input logic [N_TIMERS-1:0][CNT_W-1:0] cnt_w,
  input logic [N_TIMERS-1:0][CNT_W-1:0] reload_w,
  input logic [N_TIMERS-1:0]            run_w,
  input logic [N_TIMERS-1:0]            casc_w,
  input logic [N_TIMERS-1:0]            irqen_w,
  input logic [N_TIMERS-1:0]            ovf_w
);
  for (genvar n = 0; n < N_TIMERS; n++) begin : g_chk
    logic ctrl_hit, run_set;
    assign ctrl_hit = wr_en_i && (addr_i == ADDR_W'(2 * n + 1));
    assign run_set  = ctrl_hit && wdata_i[RUN_BIT];

    assert_start_loads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_set && !run_w[n]) |=> (cnt_w[n] == $past(reload_w[n])));

    assert_overflow_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_w[n] |=> (cnt_w[n] == $past(reload_w[n])));

    assert_stopped_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_w[n] && !run_set) |=> $stable(cnt_w[n]));

    assert_irq_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[n] |-> $past(irqen_w[n] && run_w[n] && (cnt_w[n] == '1)));

    if (n > 0) begin : g_casc
      assert_cascade_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_w[n] && casc_w[n] && !ovf_w[n-1] && !ctrl_hit) |=> $stable(cnt_w[n]));
    end
  end
endmodule

bind timer_bank timer_bank_checker #(
  .N_TIMERS (N_TIMERS),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .cnt_w    (cnt_w),
  .reload_w (reload_w),
  .run_w    (run_w),
  .casc_w   (casc_w),
  .irqen_w  (irqen_w),
  .ovf_w    (ovf_w)
);

// File: tb/timer_bank_test.sv
`timescale 1ns/1ps
module timer_bank_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [3:0]  irq_o;
  int checks = 0;
  int failures = 0;

  timer_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  // {reload, control, edges after start}
  localparam logic [39:0] VEC [8] = '{
    {16'h1000, 8'h80, 16'd10},
    {16'h0000, 8'h81, 16'd63},
    {16'h0000, 8'h81, 16'd64},
    {16'h0000, 8'h81, 16'd200},
    {16'h0010, 8'h82, 16'd600},
    {16'h0005, 8'h83, 16'd2100},
    {16'hFFF0, 8'h80, 16'd20},
    {16'h0020, 8'h84, 16'd10}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called and returns at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wait_edges(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    bit irq_seen;
    wait_edges(3);
    rst_ni = 1'b1;
    wait_edges(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, 16'h0000);
    end
    chk("R1 reset irq", {12'h0, irq_o}, 16'h0000);

    // R2 control mask
    wr(3'd3, 16'hFFFF);
    rd(3'd3, v);
    chk("R2 control mask", v, 16'h00C7);
    wr(3'd3, 16'h0000);

    // R3 R5 R10 vector table on timer 0
    for (int i = 0; i < 8; i++) begin
      logic [15:0] rl, expv;
      logic [7:0]  ct;
      int k, p, per;
      rl = VEC[i][39:24]; ct = VEC[i][23:16]; k = int'(VEC[i][15:0]);
      p = (ct[1:0] == 2'd0) ? 1 : (ct[1:0] == 2'd1) ? 64 : (ct[1:0] == 2'd2) ? 256 : 1024;
      per = 65536 - int'(rl);
      expv = 16'(int'(rl) + ((k / p) % per));
      wr(3'd1, 16'h0000);
      wr(3'd0, rl);
      wr(3'd1, {8'h00, ct});
      wait_edges(k);
      rd(3'd0, v);
      chk("R3/R5/R10 vector count", v, expv);
    end

    // R6 reload write while running
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'hFFF8);
    wr(3'd1, 16'h0080);
    wait_edges(2);
    rd(3'd0, v); chk("R6 before reload write", v, 16'hFFFA);
    wr(3'd0, 16'h1234);
    rd(3'd0, v); chk("R6 running count untouched", v, 16'hFFFB);
    wait_edges(5);
    rd(3'd0, v); chk("R6 R5 new reload at overflow", v, 16'h1234);

    // R7 freeze
    wr(3'd1, 16'h0000);
    wait_edges(10);
    rd(3'd0, v); chk("R7 frozen count", v, 16'h1235);

    // R4 start loads, re-enable does not
    wr(3'd1, 16'h0080);
    rd(3'd0, v); chk("R4 start loads reload", v, 16'h1234);
    wr(3'd1, 16'h0080);
    wait_edges(1);
    rd(3'd0, v); chk("R4 no reload while running", v, 16'h1236);

    // R8 interrupt pulse
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'hFFFC);
    wr(3'd1, 16'h00C0);
    for (int i = 1; i <= 6; i++) begin
      wait_edges(1);
      chk("R8 irq pulse timing", {12'h0, irq_o}, (i == 4) ? 16'h0001 : 16'h0000);
    end
    wr(3'd1, 16'h0000);
    wr(3'd1, 16'h0080);
    irq_seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      wait_edges(1);
      if (irq_o != 4'h0) irq_seen = 1'b1;
    end
    chk("R8 irq masked", {15'h0, irq_seen}, 16'h0000);

    // R9 cascade ignores divider select
    wr(3'd1, 16'h0000);
    wr(3'd3, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0087);
    wr(3'd0, 16'hFFFE);
    wr(3'd1, 16'h0080);
    wait_edges(10);
    rd(3'd2, v); chk("R9 cascade count", v, 16'h0005);

    // R9 ripple through three cascaded timers
    wr(3'd1, 16'h0000);
    wr(3'd3, 16'h0000);
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'h0084);
    wr(3'd4, 16'hFFFF); wr(3'd5, 16'h0084);
    wr(3'd6, 16'hFFFF); wr(3'd7, 16'h00C4);
    wr(3'd1, 16'h0080);
    wait_edges(1);
    chk("R9 ripple irq before", {12'h0, irq_o}, 16'h0000);
    wait_edges(1);
    chk("R9 ripple irq top", {12'h0, irq_o}, 16'h0008);
    wait_edges(1);
    chk("R9 ripple irq after", {12'h0, irq_o}, 16'h0000);
    rd(3'd4, v); chk("R9 ripple mid count", v, 16'hFFFF);
    rd(3'd6, v); chk("R9 ripple top count", v, 16'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule